// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Controller Acknowledge Path

This block pairs two eight-line interrupt controllers to serve sixteen request lines. Lines 0 to 7 feed the master controller and lines 8 to 15 feed the slave. The slave does not drive a line of its own. Whenever it holds a qualifying request, it raises master line 2, the cascade input. The master alone drives the single processor interrupt output.

When the processor pulses the acknowledge strobe, the block works out which controller owns the interrupt. It marks that line in service and latches an 8-bit vector. The vector is built from the owning controller's base, with the low three bits of the base replaced by the line number.

A request can disappear between the interrupt and the acknowledge. In that case the controller concerned hands out its line-7 vector as a spurious vector. In the nested cascade mode, the master leaves its own cascade in-service bit out of the current-priority comparison. This lets a higher-priority slave request interrupt a slave service routine that is already running.

Software ends each service with an end-of-interrupt strobe that names one of the sixteen lines.

Top module: `pic_cascade_ctrl`

## Requirements
- R1: While in reset and after it, until the first acknowledge, irq_out is 0 and vec_out is 8'h00.
- R2: An acknowledge whose master winner is line n (n not 2) sets vec_out to (MASTER_BASE & 8'hF8) + n from the first cycle after the acknowledge edge. With the defaults this is 8'h20 + n. vec_out then holds until the next acknowledge.
- R3: A slave request reaches irq_out after two clock edges. An acknowledge whose master winner is line 2, while the slave holds qualifying line m, gives (SLAVE_BASE & 8'hF8) + m. With the defaults this is 8'h28 + m.
- R4: An acknowledge with no qualifying master request gives the master spurious vector, master base + 7 (8'h27). It changes no in-service state.
- R5: Master line 2 stays latched after the slave request has vanished. An acknowledge in that state gives the slave spurious vector, slave base + 7 (8'h2F), and puts master line 2 in service.
- R6: Inside each controller a lower line number wins. The whole slave competes at master priority 2, below lines 0 and 1 and above lines 3 to 7.
- R7: An edge line latches a rising input. It stays pending after the input falls, until that line is acknowledged. An input held high does not request again without a fresh rising edge.
- R8: A level line follows its input. If the input drops before the acknowledge, the request is withdrawn. An acknowledge does not clear it, so a held line requests again after its end of interrupt.
- R9: Master lines 0 to 2 and slave lines 0 and 5 (global 8 and 13) are always edge triggered. With the defaults (MASTER_LEVEL = SLAVE_LEVEL = 8'hFF), every other line is level triggered.
- R10: A request is raised only when it outranks every in-service line of its controller. eoi with eoi_line 0 to 7 clears that master line. eoi_line 8 to 15 clears slave line eoi_line - 8 only.
- R11: With NESTED_SLAVE = 1, a slave request that outranks the slave line in service raises irq_out even while master line 2 is in service.
- R12: irq_lines[2] has no effect. Master line 2 is driven only by the slave.
- R13: irq_out is 0 whenever no qualifying master request exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Interrupt request lines; [7:0] master, [15:8] slave, [2] unused |
| ack | input | 1 | Single-cycle acknowledge strobe |
| eoi | input | 1 | Single-cycle end-of-interrupt strobe |
| eoi_line | input | 4 | Global line number to take out of service |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector latched at the last acknowledge |

## Verification
The assertions assume that ack and eoi are single-cycle pulses and that no end of interrupt names a line in the same cycle as an acknowledge. The state-stability and vector checks rely on both of these. The stimulus drives every strobe for exactly one clock, with at least one idle cycle between strobes. It also waits several cycles after each request change, so that the cascade's extra register stage has settled before irq_out is sampled. The sweeps drive each line once as a one-cycle pulse and once as a held level. Directed sequences then cover priority, spurious and nested cases.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;

    localparam int CTRL_LINES    = 8;
    localparam int LINE_W        = $clog2(CTRL_LINES);
    localparam int ALL_LINES     = 2 * CTRL_LINES;
    localparam int GLINE_W       = LINE_W + 1;
    localparam int VEC_W         = 8;
    localparam int CASCADE_LINE  = 2;
    localparam int SPURIOUS_LINE = CTRL_LINES - 1;

    // lines that may be level triggered; the rest are edge only
    localparam logic [CTRL_LINES-1:0] MASTER_TRIG_MASK = 8'hF8;
    localparam logic [CTRL_LINES-1:0] SLAVE_TRIG_MASK  = 8'hDE;

    typedef logic [CTRL_LINES-1:0] line_vec_t;
    typedef logic [LINE_W-1:0]     line_idx_t;
    typedef logic [VEC_W-1:0]      vector_t;

    typedef struct packed {
        logic      valid;
        line_idx_t line;
    } pick_t;

    typedef enum logic [1:0] {
        SRC_MASTER_SPUR,
        SRC_MASTER,
        SRC_SLAVE,
        SRC_SLAVE_SPUR
    } ack_src_t;

    function automatic pick_t pick_lowest(line_vec_t v);
        pick_t p;
        p.valid = 1'b0;
        p.line  = '0;
        for (int i = CTRL_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.line  = line_idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic line_vec_t line_bit(line_idx_t l);
        return line_vec_t'(1) << l;
    endfunction

    function automatic vector_t make_vector(vector_t base, line_idx_t l);
        return {base[VEC_W-1:LINE_W], l};
    endfunction

endpackage

// File: rtl/pic_trigger_stage.sv
module pic_trigger_stage
    import pic_cascade_pkg::*;
#(
    parameter line_vec_t LEVEL_SEL = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t raw,
    input  line_vec_t clr,
    input  line_vec_t set,
    output line_vec_t req
);

    for (genvar g = 0; g < CTRL_LINES; g++) begin : g_line
        logic prev_q;
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                bit_q  <= 1'b0;
            end else begin
                prev_q <= raw[g];
                if (LEVEL_SEL[g]) begin
                    bit_q <= raw[g];
                end else begin
                    bit_q <= (bit_q & ~clr[g]) | (raw[g] & ~prev_q) | set[g];
                end
            end
        end

        assign req[g] = bit_q;
    end

endmodule

// File: rtl/pic_priority_pick.sv
module pic_priority_pick
    import pic_cascade_pkg::*;
#(
    parameter bit EXCLUDE_CASCADE = 1'b0
) (
    input  line_vec_t req,
    input  line_vec_t isr,
    output pick_t     win
);

    localparam line_vec_t IGNORE_ISR =
        EXCLUDE_CASCADE ? line_vec_t'(1 << CASCADE_LINE) : line_vec_t'(0);

    pick_t want;
    pick_t cur;

    always_comb begin
        want      = pick_lowest(req);
        cur       = pick_lowest(isr & ~IGNORE_ISR);
        win.line  = want.line;
        win.valid = want.valid && (!cur.valid || (want.line < cur.line));
    end

endmodule

// File: rtl/pic_inservice_reg.sv
module pic_inservice_reg
    import pic_cascade_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t set,
    input  line_vec_t clr,
    output line_vec_t isr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            isr <= '0;
        end else begin
            isr <= (isr & ~clr) | set;
        end
    end

endmodule

// File: rtl/pic_cascade_ctrl.sv
module pic_cascade_ctrl
    import pic_cascade_pkg::*;
#(
    parameter logic [7:0] MASTER_BASE  = 8'h23,
    parameter logic [7:0] SLAVE_BASE   = 8'h2D,
    parameter logic [7:0] MASTER_LEVEL = 8'hFF,
    parameter logic [7:0] SLAVE_LEVEL  = 8'hFF,
    parameter bit         NESTED_SLAVE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] irq_lines,
    input  logic        ack,
    input  logic        eoi,
    input  logic [3:0]  eoi_line,
    output logic        irq_out,
    output logic [7:0]  vec_out
);

    localparam line_vec_t M_LEVEL  = MASTER_LEVEL & MASTER_TRIG_MASK;
    localparam line_vec_t S_LEVEL  = SLAVE_LEVEL & SLAVE_TRIG_MASK;
    localparam line_vec_t CASC_BIT = line_vec_t'(1 << CASCADE_LINE);

    line_vec_t m_raw, s_raw;
    line_vec_t m_req, s_req;
    line_vec_t m_isr, s_isr;
    line_vec_t m_clr_req, s_clr_req;
    line_vec_t m_set_isr, s_set_isr;
    line_vec_t m_eoi, s_eoi;
    line_vec_t casc_set;
    pick_t     m_pick, s_pick;
    ack_src_t  src;
    vector_t   next_vec;
    vector_t   vec_q;

    // request inputs; master cascade input comes only from the slave
    always_comb begin
        m_raw    = irq_lines[CTRL_LINES-1:0] & ~CASC_BIT;
        s_raw    = irq_lines[ALL_LINES-1:CTRL_LINES];
        casc_set = (s_pick.valid && !ack) ? CASC_BIT : '0;
    end

    pic_trigger_stage #(.LEVEL_SEL(M_LEVEL)) u_m_trig (
        .clk(clk), .rst(rst), .raw(m_raw), .clr(m_clr_req),
        .set(casc_set), .req(m_req)
    );

    pic_trigger_stage #(.LEVEL_SEL(S_LEVEL)) u_s_trig (
        .clk(clk), .rst(rst), .raw(s_raw), .clr(s_clr_req),
        .set('0), .req(s_req)
    );

    pic_priority_pick #(.EXCLUDE_CASCADE(NESTED_SLAVE)) u_m_pick (
        .req(m_req), .isr(m_isr), .win(m_pick)
    );

    pic_priority_pick #(.EXCLUDE_CASCADE(1'b0)) u_s_pick (
        .req(s_req), .isr(s_isr), .win(s_pick)
    );

    // acknowledge resolution
    always_comb begin
        if (!m_pick.valid) begin
            src = SRC_MASTER_SPUR;
        end else if (m_pick.line == line_idx_t'(CASCADE_LINE)) begin
            src = s_pick.valid ? SRC_SLAVE : SRC_SLAVE_SPUR;
        end else begin
            src = SRC_MASTER;
        end

        m_set_isr = '0;
        s_set_isr = '0;
        m_clr_req = '0;
        s_clr_req = '0;
        if (ack && m_pick.valid) begin
            m_set_isr = line_bit(m_pick.line);
            m_clr_req = line_bit(m_pick.line);
        end
        if (ack && src == SRC_SLAVE) begin
            s_set_isr = line_bit(s_pick.line);
            s_clr_req = line_bit(s_pick.line);
        end

        unique case (src)
            SRC_MASTER:      next_vec = make_vector(MASTER_BASE, m_pick.line);
            SRC_SLAVE:       next_vec = make_vector(SLAVE_BASE, s_pick.line);
            SRC_SLAVE_SPUR:  next_vec = make_vector(SLAVE_BASE, line_idx_t'(SPURIOUS_LINE));
            default:         next_vec = make_vector(MASTER_BASE, line_idx_t'(SPURIOUS_LINE));
        endcase
    end

    // end-of-interrupt decode: top bit of the line selects the controller
    always_comb begin
        m_eoi = '0;
        s_eoi = '0;
        if (eoi) begin
            if (eoi_line[GLINE_W-1]) s_eoi = line_bit(eoi_line[LINE_W-1:0]);
            else                     m_eoi = line_bit(eoi_line[LINE_W-1:0]);
        end
    end

    pic_inservice_reg u_m_isr (
        .clk(clk), .rst(rst), .set(m_set_isr), .clr(m_eoi), .isr(m_isr)
    );

    pic_inservice_reg u_s_isr (
        .clk(clk), .rst(rst), .set(s_set_isr), .clr(s_eoi), .isr(s_isr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (ack) begin
            vec_q <= next_vec;
        end
    end

    assign irq_out = m_pick.valid;
    assign vec_out = vec_q;

endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk
    import pic_cascade_pkg::*;
#(
    parameter logic [7:0] MASTER_BASE = 8'h23,
    parameter logic [7:0] SLAVE_BASE  = 8'h2D
) (
    input logic      clk,
    input logic      rst,
    input logic      ack,
    input logic      eoi,
    input logic      irq_out,
    input logic [7:0] vec_out,
    input line_vec_t m_req,
    input line_vec_t m_isr,
    input line_vec_t s_isr
);

    // R4
    spur_vector_chk: assert property (@(posedge clk) disable iff (rst)
        ack && !irq_out |=> vec_out == {MASTER_BASE[7:3], 3'd7});

    // R4
    spur_state_chk: assert property (@(posedge clk) disable iff (rst)
        ack && !irq_out && !eoi |=> $stable(m_isr) && $stable(s_isr));

    // R2
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ack |=> $stable(vec_out));

    // R3
    vec_base_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> (vec_out[7:3] == MASTER_BASE[7:3]) || (vec_out[7:3] == SLAVE_BASE[7:3]));

    // R13
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        m_req == '0 |-> !irq_out);

    // R10
    mark_service_chk: assert property (@(posedge clk) disable iff (rst)
        ack && irq_out |=> m_isr != '0);

endmodule

bind pic_cascade_ctrl pic_cascade_chk #(
    .MASTER_BASE(MASTER_BASE),
    .SLAVE_BASE(SLAVE_BASE)
) u_chk (
    .clk(clk), .rst(rst), .ack(ack), .eoi(eoi), .irq_out(irq_out),
    .vec_out(vec_out), .m_req(m_req), .m_isr(m_isr), .s_isr(s_isr)
);

// File: tb/pic_cascade_ctrl_tb.sv
module pic_cascade_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lines = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic [3:0]  eoi_line = '0;
    logic        irq_out;
    logic [7:0]  vec_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pic_cascade_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_lines(lines), .ack(ack), .eoi(eoi),
        .eoi_line(eoi_line), .irq_out(irq_out), .vec_out(vec_out)
    );

    always #10ns clk = ~clk;

    function automatic bit is_edge(int l);
        return (l == 0) || (l == 1) || (l == 2) || (l == 8) || (l == 13);
    endfunction

    function automatic logic [7:0] exp_vec(int l);
        return (l < 8) ? 8'(8'h20 + l) : 8'(8'h28 + l - 8);
    endfunction

    task automatic chk1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s irq_out actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s vec_out actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_eoi(int l);
        eoi = 1'b1;
        eoi_line = 4'(l);
        @(negedge clk);
        eoi = 1'b0;
        cyc(1);
    endtask

    initial begin
        #5ms;
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-R actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk1("R1 in reset", irq_out, 1'b0);
        chk8("R1 in reset", vec_out, 8'h00);
        rst = 1'b0;
        cyc(2);
        chk1("R1 after reset", irq_out, 1'b0);
        chk8("R1 after reset", vec_out, 8'h00);

        // R4: acknowledge with nothing pending
        do_ack();
        chk8("R4 idle ack", vec_out, 8'h27);
        chk1("R13 idle", irq_out, 1'b0);

        // sweep 1: one-cycle pulse on each line (R7 R8 R9 R5)
        for (int l = 0; l < 16; l++) begin
            if (l == 2) continue;
            lines[l] = 1'b1;
            cyc(1);
            lines[l] = 1'b0;
            cyc(3);
            chk1($sformatf("R9 pulse line %0d", l), irq_out, is_edge(l) || l >= 8);
            do_ack();
            if (is_edge(l))  chk8($sformatf("R7 pulse line %0d", l), vec_out, exp_vec(l));
            else if (l < 8)  chk8($sformatf("R8 pulse line %0d", l), vec_out, 8'h27);
            else             chk8($sformatf("R5 pulse line %0d", l), vec_out, 8'h2F);
            if (is_edge(l)) do_eoi(l);
            if (l >= 8)     do_eoi(2);
            cyc(3);
            chk1($sformatf("R13 after pulse %0d", l), irq_out, 1'b0);
        end

        // sweep 2: held level on each line (R2 R3 R7 R8 R10)
        for (int l = 0; l < 16; l++) begin
            if (l == 2) continue;
            lines[l] = 1'b1;
            cyc(4);
            chk1($sformatf("R3 held line %0d", l), irq_out, 1'b1);
            do_ack();
            chk8($sformatf("R2 held line %0d", l), vec_out, exp_vec(l));
            cyc(1);
            chk1($sformatf("R10 in service %0d", l), irq_out, 1'b0);
            do_eoi(l);
            if (l >= 8) do_eoi(2);
            cyc(3);
            chk1($sformatf("R7 R8 after eoi %0d", l), irq_out, !is_edge(l));
            if (!is_edge(l)) begin
                do_ack();
                chk8($sformatf("R8 re-request %0d", l), vec_out, exp_vec(l));
                lines[l] = 1'b0;
                do_eoi(l);
                if (l >= 8) do_eoi(2);
            end else begin
                lines[l] = 1'b0;
            end
            cyc(3);
            chk1($sformatf("R13 after hold %0d", l), irq_out, 1'b0);
        end

        // R12: master line 2 input is ignored
        lines[2] = 1'b1;
        cyc(4);
        chk1("R12 held", irq_out, 1'b0);
        do_ack();
        chk8("R12 ack", vec_out, 8'h27);
        lines[2] = 1'b0;
        cyc(1);
        lines[2] = 1'b1;
        cyc(1);
        lines[2] = 1'b0;
        cyc(3);
        chk1("R12 pulse", irq_out, 1'b0);

        // R6: two master level lines
        lines[3] = 1'b1;
        lines[5] = 1'b1;
        cyc(3);
        do_ack();
        chk8("R6 master order", vec_out, 8'h23);
        cyc(1);
        chk1("R10 lower blocked", irq_out, 1'b0);
        lines[3] = 1'b0;
        cyc(1);
        do_eoi(3);
        chk1("R10 eoi releases", irq_out, 1'b1);
        do_ack();
        chk8("R6 second", vec_out, 8'h25);
        lines[5] = 1'b0;
        do_eoi(5);
        cyc(3);
        chk1("R13 after R6 a", irq_out, 1'b0);

        // R6: slave group outranks master line 4
        lines[11] = 1'b1;
        lines[4]  = 1'b1;
        cyc(4);
        do_ack();
        chk8("R6 slave over 4", vec_out, 8'h2B);
        lines[11] = 1'b0;
        lines[4]  = 1'b0;
        cyc(1);
        do_eoi(11);
        do_eoi(2);
        cyc(3);
        chk1("R13 after R6 b", irq_out, 1'b0);

        // R6: master line 1 outranks slave group
        lines[1] = 1'b1;
        lines[9] = 1'b1;
        cyc(1);
        lines[1] = 1'b0;
        cyc(3);
        do_ack();
        chk8("R6 line1 over slave", vec_out, 8'h21);
        cyc(1);
        chk1("R10 cascade blocked", irq_out, 1'b0);
        do_eoi(1);
        chk1("R10 cascade released", irq_out, 1'b1);
        do_ack();
        chk8("R3 slave after", vec_out, 8'h29);
        lines[9] = 1'b0;
        do_eoi(9);
        do_eoi(2);
        cyc(3);
        chk1("R13 after R6 c", irq_out, 1'b0);

        // R11: nested slave request while cascade line is in service
        lines[9] = 1'b1;
        cyc(4);
        do_ack();
        chk8("R11 first", vec_out, 8'h29);
        cyc(1);
        chk1("R11 idle", irq_out, 1'b0);
        lines[8] = 1'b1;
        cyc(1);
        lines[8] = 1'b0;
        cyc(3);
        chk1("R11 nested raise", irq_out, 1'b1);
        do_ack();
        chk8("R11 nested vector", vec_out, 8'h28);
        lines[9] = 1'b0;
        do_eoi(8);
        do_eoi(9);
        do_eoi(2);
        cyc(3);
        chk1("R13 final", irq_out, 1'b0);
        chk8("R2 vec held", vec_out, 8'h28);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule